// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a two-part logical address (a segment number and an offset within that segment) into a flat physical address. A small table held in registers describes each segment. An entry gives the segment's physical start address, its length, whether it is usable, and which kinds of access (read, write, instruction fetch) it allows. A separate register holds how many table entries are in use. A request is translated only if it passes every check. Otherwise it returns a two-bit code that names the first check it failed.

Requests and responses each use a valid/ready handshake, with a single registered stage between them. The answer to an accepted request therefore appears on the next clock edge, and it stays there until the consumer takes it. Table entries and the in-use count are loaded through a plain write port. A write takes effect for requests accepted on later cycles.

Top module: `seg_xlate_unit`

## Requirements
- R1: A request that passes every check returns rsp_fault = 0 and rsp_paddr = (entry start address + offset) modulo 2^PA_BITS.
- R2: A segment number equal to or above the in-use count faults with code 0. This check has the highest priority.
- R3: A segment whose entry has its usable bit clear faults with code 1.
- R4: An offset equal to or above the entry's length faults with code 2. An offset of length-1 is accepted.
- R5: The access kind is encoded 0 = read, 1 = write, 2 = fetch, 3 = reserved. Kinds 0, 1 and 2 need permission bit 0, 1 and 2 of the entry respectively. Kind 3 is never permitted. A missing permission faults with code 3.
- R6: When several checks fail at once, the code reported is the one for the earliest failing check, in the order R2, R3, R4, R5.
- R7: A faulting response drives rsp_paddr to zero.
- R8: req_ready is high whenever no response is pending or rsp_ready is high. An accepted request produces rsp_valid on the next clock edge. A response that is not taken holds its valid, fault, code and address unchanged.
- R9: A table or count write that happens on the same edge as a request's acceptance does not affect that request. It does affect a request accepted on the next edge.
- R10: After reset, rsp_valid is 0, req_ready is 1, the in-use count is 0 and every entry is unusable. A first request therefore faults with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_seg | input | SEG_BITS | Segment number |
| req_off | input | OFF_BITS | Offset within the segment |
| req_acc | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 reserved) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_paddr | output | PA_BITS | Physical address, zero on fault |
| rsp_fault | output | 1 | Translation refused |
| rsp_code | output | 2 | Failed check: 0 range, 1 unusable, 2 length, 3 permission |
| cfg_entry_we | input | 1 | Write one table entry |
| cfg_idx | input | SEG_BITS | Entry being written |
| cfg_base | input | PA_BITS | Segment start address |
| cfg_limit | input | OFF_BITS+1 | Segment length |
| cfg_valid | input | 1 | Usable bit for the entry |
| cfg_perm | input | 3 | Permission bits: 0 read, 1 write, 2 fetch |
| cfg_count_we | input | 1 | Write the in-use count |
| cfg_count | input | SEG_BITS+1 | Number of entries in use |

## Verification
The result of a request accepted on edge N appears on the outputs after edge N and holds until a later edge on which rsp_ready is high. req_ready follows rsp_valid and rsp_ready with no delay. The bench drives inputs on the falling edge and keeps a reference model that is updated on the same rising edges as the design. Half a nanosecond after each falling edge it compares every output against that model, so each result is checked in exactly the cycle in which it is due. Configuration writes that coincide with an accepted request are applied in the model after the lookup, which pins the one-cycle visibility of R9.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   typedef enum logic [1:0] {
      FLT_RANGE   = 2'd0,
      FLT_UNUSED  = 2'd1,
      FLT_LENGTH  = 2'd2,
      FLT_PERM    = 2'd3
   } flt_code_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   localparam int PERM_W = 3;
   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_EX = 2;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_BITS = 3,
   parameter int OFF_BITS = 12,
   parameter int PA_BITS  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEG_BITS-1:0]  wr_idx,
   input  logic [PA_BITS-1:0]   wr_base,
   input  logic [OFF_BITS:0]    wr_limit,
   input  logic                 wr_valid,
   input  logic [seg_xlate_pkg::PERM_W-1:0] wr_perm,
   input  logic                 cnt_we,
   input  logic [SEG_BITS:0]    cnt_data,
   input  logic [SEG_BITS-1:0]  rd_idx,
   output logic [PA_BITS-1:0]   rd_base,
   output logic [OFF_BITS:0]    rd_limit,
   output logic                 rd_valid,
   output logic [seg_xlate_pkg::PERM_W-1:0] rd_perm,
   output logic [SEG_BITS:0]    cnt_q,
   output logic [(1<<SEG_BITS)-1:0] valid_vec
);
   localparam int NUM_SEGS = 1 << SEG_BITS;
   localparam int PW = seg_xlate_pkg::PERM_W;

   logic [NUM_SEGS-1:0][PA_BITS-1:0]  base_all;
   logic [NUM_SEGS-1:0][OFF_BITS:0]   limit_all;
   logic [NUM_SEGS-1:0][PW-1:0]       perm_all;

   for (genvar i = 0; i < NUM_SEGS; i++) begin : g_ent
      logic [PA_BITS-1:0]  base_r;
      logic [OFF_BITS:0]   limit_r;
      logic [PW-1:0]       perm_r;
      logic                valid_r;
      logic                hit;

      assign hit = wr_en && (wr_idx == SEG_BITS'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_r  <= '0;
            limit_r <= '0;
            perm_r  <= '0;
            valid_r <= 1'b0;
         end else if (hit) begin
            base_r  <= wr_base;
            limit_r <= wr_limit;
            perm_r  <= wr_perm;
            valid_r <= wr_valid;
         end
      end

      assign base_all[i]  = base_r;
      assign limit_all[i] = limit_r;
      assign perm_all[i]  = perm_r;
      assign valid_vec[i] = valid_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_we) cnt_q <= cnt_data;
   end

   assign rd_base  = base_all[rd_idx];
   assign rd_limit = limit_all[rd_idx];
   assign rd_perm  = perm_all[rd_idx];
   assign rd_valid = valid_vec[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int SEG_BITS = 3,
   parameter int OFF_BITS = 12,
   parameter int PA_BITS  = 16
) (
   input  logic [SEG_BITS-1:0] seg,
   input  logic [OFF_BITS-1:0] off,
   input  logic [1:0]          acc,
   input  logic [SEG_BITS:0]   cnt,
   input  logic                ent_valid,
   input  logic [PA_BITS-1:0]  ent_base,
   input  logic [OFF_BITS:0]   ent_limit,
   input  logic [PERM_W-1:0]   ent_perm,
   output logic                fault,
   output logic [1:0]          code,
   output logic [PA_BITS-1:0]  paddr
);
   logic in_range, in_length, allowed;
   logic [PA_BITS-1:0] sum;

   assign in_range  = {1'b0, seg} < cnt;
   assign in_length = {1'b0, off} < ent_limit;
   assign sum       = ent_base + PA_BITS'(off);

   always_comb begin
      unique case (acc_kind_e'(acc))
         ACC_READ:  allowed = ent_perm[PERM_RD];
         ACC_WRITE: allowed = ent_perm[PERM_WR];
         ACC_FETCH: allowed = ent_perm[PERM_EX];
         default:   allowed = 1'b0;
      endcase
   end

   always_comb begin
      fault = 1'b1;
      code  = FLT_RANGE;
      if (!in_range)       code = FLT_RANGE;
      else if (!ent_valid) code = FLT_UNUSED;
      else if (!in_length) code = FLT_LENGTH;
      else if (!allowed)   code = FLT_PERM;
      else begin
         fault = 1'b0;
         code  = FLT_RANGE;
      end
      paddr = fault ? '0 : sum;
   end
endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg #(
   parameter int PA_BITS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [PA_BITS-1:0] in_paddr,
   input  logic               in_fault,
   input  logic [1:0]         in_code,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [PA_BITS-1:0] out_paddr,
   output logic               out_fault,
   output logic [1:0]         out_code
);
   logic take;

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_paddr <= '0;
         out_fault <= 1'b0;
         out_code  <= '0;
      end else begin
         if (take) begin
            out_valid <= 1'b1;
            out_paddr <= in_paddr;
            out_fault <= in_fault;
            out_code  <= in_code;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int SEG_BITS = 3,
   parameter int OFF_BITS = 12,
   parameter int PA_BITS  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [SEG_BITS-1:0]  req_seg,
   input  logic [OFF_BITS-1:0]  req_off,
   input  logic [1:0]           req_acc,
   output logic                 rsp_valid,
   input  logic                 rsp_ready,
   output logic [PA_BITS-1:0]   rsp_paddr,
   output logic                 rsp_fault,
   output logic [1:0]           rsp_code,
   input  logic                 cfg_entry_we,
   input  logic [SEG_BITS-1:0]  cfg_idx,
   input  logic [PA_BITS-1:0]   cfg_base,
   input  logic [OFF_BITS:0]    cfg_limit,
   input  logic                 cfg_valid,
   input  logic [2:0]           cfg_perm,
   input  logic                 cfg_count_we,
   input  logic [SEG_BITS:0]    cfg_count
);
   localparam int NUM_SEGS = 1 << SEG_BITS;

   if (SEG_BITS < 1 || SEG_BITS > 6) begin : g_bad_seg
      $error("seg_xlate_unit: SEG_BITS must lie in 1..6");
   end
   if (PA_BITS < OFF_BITS) begin : g_bad_pa
      $error("seg_xlate_unit: PA_BITS must not be below OFF_BITS");
   end
   if (PERM_W != 3) begin : g_bad_perm
      $error("seg_xlate_unit: permission field must be three bits");
   end

   logic [PA_BITS-1:0]  ent_base;
   logic [OFF_BITS:0]   ent_limit;
   logic                ent_valid;
   logic [PERM_W-1:0]   ent_perm;
   logic [SEG_BITS:0]   seg_cnt;
   logic [NUM_SEGS-1:0] valid_vec;
   logic                chk_fault;
   logic [1:0]          chk_code;
   logic [PA_BITS-1:0]  chk_paddr;

   seg_table #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_entry_we),
      .wr_idx    (cfg_idx),
      .wr_base   (cfg_base),
      .wr_limit  (cfg_limit),
      .wr_valid  (cfg_valid),
      .wr_perm   (cfg_perm),
      .cnt_we    (cfg_count_we),
      .cnt_data  (cfg_count),
      .rd_idx    (req_seg),
      .rd_base   (ent_base),
      .rd_limit  (ent_limit),
      .rd_valid  (ent_valid),
      .rd_perm   (ent_perm),
      .cnt_q     (seg_cnt),
      .valid_vec (valid_vec)
   );

   seg_check #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)) u_check (
      .seg       (req_seg),
      .off       (req_off),
      .acc       (req_acc),
      .cnt       (seg_cnt),
      .ent_valid (ent_valid),
      .ent_base  (ent_base),
      .ent_limit (ent_limit),
      .ent_perm  (ent_perm),
      .fault     (chk_fault),
      .code      (chk_code),
      .paddr     (chk_paddr)
   );

   seg_rsp_reg #(.PA_BITS(PA_BITS)) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_ready  (req_ready),
      .in_paddr  (chk_paddr),
      .in_fault  (chk_fault),
      .in_code   (chk_code),
      .out_valid (rsp_valid),
      .out_ready (rsp_ready),
      .out_paddr (rsp_paddr),
      .out_fault (rsp_fault),
      .out_code  (rsp_code)
   );
endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk #(
   parameter int SEG_BITS = 3,
   parameter int PA_BITS  = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req_valid,
   input logic                      req_ready,
   input logic [SEG_BITS-1:0]       req_seg,
   input logic                      rsp_valid,
   input logic                      rsp_ready,
   input logic [PA_BITS-1:0]        rsp_paddr,
   input logic                      rsp_fault,
   input logic [1:0]                rsp_code,
   input logic [SEG_BITS:0]         seg_cnt,
   input logic [(1<<SEG_BITS)-1:0]  valid_vec
);
   logic accept;
   assign accept = req_valid && req_ready;

   a_r8_result_next: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);

   a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_code)));

   a_r8_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> req_ready);

   a_r2_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ({1'b0, req_seg} >= seg_cnt)) |=> (rsp_fault && rsp_code == 2'd0));

   a_r3_unusable: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ({1'b0, req_seg} < seg_cnt) && !valid_vec[req_seg])
         |=> (rsp_fault && rsp_code == 2'd1));

   a_r7_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(.SEG_BITS(SEG_BITS), .PA_BITS(PA_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_seg   (req_seg),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .rsp_paddr (rsp_paddr),
   .rsp_fault (rsp_fault),
   .rsp_code  (rsp_code),
   .seg_cnt   (seg_cnt),
   .valid_vec (valid_vec)
);

// File: tb/seg_xlate_unit_test.sv
`timescale 1ns/1ps
module seg_xlate_unit_test;
   localparam int SB = 3;
   localparam int OB = 12;
   localparam int PB = 16;
   localparam int NS = 1 << SB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, rsp_ready = 1'b1;
   logic req_ready, rsp_valid, rsp_fault;
   logic [SB-1:0] req_seg = '0;
   logic [OB-1:0] req_off = '0;
   logic [1:0] req_acc = '0;
   logic [PB-1:0] rsp_paddr;
   logic [1:0] rsp_code;
   logic cfg_entry_we = 1'b0, cfg_valid = 1'b0, cfg_count_we = 1'b0;
   logic [SB-1:0] cfg_idx = '0;
   logic [PB-1:0] cfg_base = '0;
   logic [OB:0] cfg_limit = '0;
   logic [2:0] cfg_perm = '0;
   logic [SB:0] cfg_count = '0;

   always #2 clk = ~clk;

   seg_xlate_unit #(.SEG_BITS(SB), .OFF_BITS(OB), .PA_BITS(PB)) uut (.*);

   int vectors = 0;
   int misses = 0;
   int cycles = 0;
   string cur_req = "R10";

   // behavioural reference model
   int m_base[NS];
   int m_lim[NS];
   int m_perm[NS];
   bit m_val[NS];
   int m_cnt;
   bit e_valid;
   bit e_fault;
   int e_code;
   int e_paddr;

   task automatic lookup(input int s, input int o, input int a,
                         output bit f, output int c, output int pa);
      f = 1; c = 0; pa = 0;
      if (s >= m_cnt) c = 0;
      else if (!m_val[s]) c = 1;
      else if (o >= m_lim[s]) c = 2;
      else if (a == 3 || ((m_perm[s] >> a) & 1) == 0) c = 3;
      else begin
         f = 0;
         pa = (m_base[s] + o) % (1 << PB);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            m_base[i] <= 0; m_lim[i] <= 0; m_perm[i] <= 0; m_val[i] <= 0;
         end
         m_cnt <= 0;
         e_valid <= 0; e_fault <= 0; e_code <= 0; e_paddr <= 0;
      end else begin
         if (req_valid && (!e_valid || rsp_ready)) begin
            bit f; int c; int pa;
            lookup(int'(req_seg), int'(req_off), int'(req_acc), f, c, pa);
            e_valid <= 1; e_fault <= f; e_code <= c; e_paddr <= pa;
         end else if (rsp_ready) begin
            e_valid <= 0;
         end
         if (cfg_entry_we) begin
            m_base[cfg_idx] <= int'(cfg_base);
            m_lim[cfg_idx]  <= int'(cfg_limit);
            m_perm[cfg_idx] <= int'(cfg_perm);
            m_val[cfg_idx]  <= cfg_valid;
         end
         if (cfg_count_we) m_cnt <= int'(cfg_count);
      end
   end

   always @(negedge clk) begin
      #0.5;
      if (rst_n) begin
         bit bad;
         bad = 0;
         vectors++;
         if (req_ready !== (!e_valid || rsp_ready)) bad = 1;
         if (rsp_valid !== e_valid) bad = 1;
         if (e_valid) begin
            if (rsp_fault !== e_fault) bad = 1;
            if (e_fault && int'(rsp_code) != e_code) bad = 1;
            if (int'(rsp_paddr) != e_paddr) bad = 1;
         end
         if (bad) begin
            misses++;
            $display("FAIL %s t=%0t actual rdy=%b vld=%b flt=%b code=%0d pa=%h expected rdy=%b vld=%b flt=%b code=%0d pa=%h",
                     cur_req, $time, req_ready, rsp_valid, rsp_fault, rsp_code, rsp_paddr,
                     (!e_valid || rsp_ready), e_valid, e_fault, e_code, e_paddr[PB-1:0]);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         misses++;
         $display("FAIL watchdog expired actual=%0d expected<=50000 cycles", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   // caller is at a falling edge; each task ends at a falling edge
   task automatic put_entry(input int idx, input int base, input int lim, input bit v, input int perm);
      cfg_entry_we = 1; cfg_idx = SB'(idx); cfg_base = PB'(base);
      cfg_limit = (OB+1)'(lim); cfg_valid = v; cfg_perm = 3'(perm);
      @(negedge clk);
      cfg_entry_we = 0;
   endtask

   task automatic put_count(input int n);
      cfg_count_we = 1; cfg_count = (SB+1)'(n);
      @(negedge clk);
      cfg_count_we = 0;
   endtask

   task automatic ask(input int s, input int o, input int a);
      req_valid = 1; req_seg = SB'(s); req_off = OB'(o); req_acc = 2'(a);
      @(negedge clk);
      req_valid = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      cur_req = "R10";
      ask(0, 0, 0);
      ask(5, 10, 1);
      @(negedge clk);

      put_count(4);
      put_entry(0, 'h1000, 'h100, 1, 3'b001);
      put_entry(1, 'h2000, 'h800, 1, 3'b111);
      put_entry(2, 'h3000, 'h200, 0, 3'b111);
      put_entry(3, 'hFF00, 'h1000, 1, 3'b110);
      put_entry(5, 'h5000, 'h10, 1, 3'b111);

      cur_req = "R1";
      ask(0, 'h20, 0);
      ask(1, 'h7FF, 1);
      ask(1, 0, 2);
      ask(3, 'h1FF, 1);   // wraps past the top of the address space
      cur_req = "R2";
      ask(4, 0, 0);
      ask(5, 1, 0);
      ask(7, 0, 0);
      cur_req = "R3";
      ask(2, 0, 0);
      cur_req = "R4";
      ask(0, 'hFF, 0);
      ask(0, 'h100, 0);
      ask(1, 'hFFF, 0);
      cur_req = "R5";
      ask(0, 0, 1);
      ask(0, 0, 2);
      ask(1, 0, 3);
      ask(3, 0, 0);
      ask(3, 0, 2);
      cur_req = "R6";
      ask(2, 'hFFF, 3);   // unusable beats length and permission
      ask(0, 'h200, 1);   // length beats permission
      ask(6, 'hFFF, 3);   // range beats everything
      cur_req = "R7";
      ask(0, 'h150, 0);

      cur_req = "R8";
      rsp_ready = 0;
      req_valid = 1; req_seg = 1; req_off = 12'h10; req_acc = 0;
      @(negedge clk);
      req_seg = 0; req_off = 12'h5;
      repeat (3) @(negedge clk);
      rsp_ready = 1;
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      rsp_ready = 0;
      @(negedge clk);
      rsp_ready = 1;
      @(negedge clk);

      cur_req = "R9";
      cfg_entry_we = 1; cfg_idx = 2; cfg_base = 16'h4400; cfg_limit = 13'h40;
      cfg_valid = 1; cfg_perm = 3'b001;
      req_valid = 1; req_seg = 2; req_off = 12'h8; req_acc = 0;
      @(negedge clk);
      cfg_entry_we = 0;
      @(negedge clk);
      req_valid = 0;
      cfg_count_we = 1; cfg_count = 8;
      req_valid = 1; req_seg = 5; req_off = 12'h3; req_acc = 0;
      @(negedge clk);
      cfg_count_we = 0;
      @(negedge clk);
      req_valid = 0;
      repeat (2) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule